// File: doc/BRIEF.md
# Lockable Clock-Gated Plastic Synapse

This block is one plastic connection of a small spiking reinforcement-learning network. It holds a signed fixed-point weight. It passes that weight to the post-synaptic neuron whenever the pre-synaptic neuron spikes. During replay it strengthens the weight (potentiation) or weakens it (depression) by a fixed step. The step saturates at the limits of the weight range instead of wrapping.

Once a replay run has changed the weight, a stored freeze bit holds the weight fixed until a context-change pulse releases it. The freeze bit is also set at once when an update drives the weight to either limit. The synapse produces its own clock enable and keeps it low when it has nothing to do. Its state registers only advance in enabled cycles, so a frozen, idle synapse stops switching.

A replay run is a stretch of consecutive cycles with `replay_i` high. The first cycle with `replay_i` low after a run that applied at least one step closes that run.

Top module: `plastic_syn_lock`

## Requirements
- R1: While reset is held and for as long as no input is active afterwards, the weight equals `seed_i`, the freeze bit is clear, `post_o` is 0 and `clk_en_o` is 0.
- R2: In the cycle after a cycle with `pre_spike_i`=1, `post_o` equals the weight held in the spike cycle. In the cycle after a cycle with `pre_spike_i`=0, `post_o` is 0.
- R3: Each cycle with `replay_i`=1, `ltp_sel_i`=1 and `unlock_i`=0 on an unfrozen synapse adds STEP (default 16) to the weight.
- R4: Each such cycle with `ltp_sel_i`=0 subtracts STEP from the weight.
- R5: The weight is an 8-bit two's-complement value. It saturates at +127 and -128. An update whose result lies at either limit freezes the synapse at the same clock edge.
- R6: In the first cycle with `replay_i`=0 after a replay run that applied a step, the synapse freezes, and `clk_en_o` is 1 during that cycle. While frozen, replay cycles leave the weight unchanged.
- R7: A cycle with `unlock_i`=1 drives `clk_en_o` to 1, clears the freeze bit and applies no step in that cycle, even when `replay_i`=1. The next replay cycle updates the weight again.
- R8: `clk_en_o` is 0 when `pre_spike_i`, `replay_i` and `unlock_i` are all 0, the previous enabled cycle had no spike, and no closed replay run is waiting to freeze.
- R9: A frozen synapse with `replay_i`=1, `unlock_i`=0 and no spike in the current or the previous enabled cycle keeps `clk_en_o` at 0.
- R10: In a cycle with `clk_en_o`=0, the weight, the freeze bit and `post_o` keep their values at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| seed_i | input | W | Initial weight, loaded while in reset |
| pre_spike_i | input | 1 | Pre-synaptic spike |
| replay_i | input | 1 | Replay active this cycle |
| ltp_sel_i | input | 1 | 1 = potentiate, 0 = depress |
| unlock_i | input | 1 | Context-change pulse that clears the freeze bit |
| post_o | output | W | Registered weighted output to the post-synaptic neuron |
| clk_en_o | output | 1 | Local clock enable for the synapse |

## Verification
The assertions check on every cycle that:
- a frozen weight stays put;
- nothing changes in a gated cycle;
- an unlock clears the freeze bit;
- an unsaturated step moves the weight by exactly STEP;
- the output falls to zero after a spike-free cycle;
- a frozen synapse in replay keeps its clock off.

The bench scenarios show what no single-cycle property can. These are the full weight trajectories through several replay runs, freezing at the end of a run, saturation and freezing at both limits, and the fact that an unlock applies no step in its own cycle. The weight is read back through ordinary spikes.

// File: rtl/syn_pkg.sv
package syn_pkg;
  typedef enum logic {
    DIR_DEPRESS = 1'b0,
    DIR_POTENT  = 1'b1
  } dir_e;
endpackage

// File: rtl/syn_rst_sync.sv
module syn_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) chain_q[s] <= 1'b0;
          else         chain_q[s] <= 1'b1;
        end
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) chain_q[s] <= 1'b0;
          else         chain_q[s] <= chain_q[s-1];
        end
      end
    end
  endgenerate

  assign rst_sync_no = chain_q[STAGES-1];
endmodule

// File: rtl/syn_step_sat.sv
module syn_step_sat #(
  parameter int W    = 8,
  parameter int STEP = 16
) (
  input  logic signed [W-1:0] w_i,
  input  syn_pkg::dir_e       dir_i,
  output logic signed [W-1:0] w_o,
  output logic                lim_o
);
  localparam logic signed [W:0] MAXV  = {2'b00, {(W-1){1'b1}}};
  localparam logic signed [W:0] MINV  = {2'b11, {(W-1){1'b0}}};
  localparam logic signed [W:0] STEPV = (W+1)'(STEP);

  logic signed [W:0] ext;
  logic signed [W:0] sum;

  always_comb begin
    ext = {w_i[W-1], w_i};
    if (dir_i == syn_pkg::DIR_POTENT) sum = ext + STEPV;
    else                              sum = ext - STEPV;
    if (sum > MAXV)      w_o = MAXV[W-1:0];
    else if (sum < MINV) w_o = MINV[W-1:0];
    else                 w_o = sum[W-1:0];
    lim_o = (w_o == MAXV[W-1:0]) || (w_o == MINV[W-1:0]);
  end
endmodule

// File: rtl/syn_gate_ctl.sv
module syn_gate_ctl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pre_spike_i,
  input  logic spike_q_i,
  input  logic replay_i,
  input  logic unlock_i,
  input  logic lim_i,
  output logic en_o,
  output logic apply_o,
  output logic lock_o
);
  logic lock_q, lock_d;
  logic pend_q, pend_d;

  always_comb begin
    apply_o = replay_i & ~lock_q & ~unlock_i;
    en_o    = pre_spike_i | spike_q_i | unlock_i | (~lock_q & (replay_i | pend_q));

    lock_d = lock_q;
    pend_d = pend_q;
    if (unlock_i) begin
      lock_d = 1'b0;
      pend_d = 1'b0;
    end else if (apply_o && lim_i) begin
      lock_d = 1'b1;
      pend_d = 1'b0;
    end else if (apply_o) begin
      pend_d = 1'b1;
    end else if (!replay_i && pend_q) begin
      lock_d = 1'b1;
      pend_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_q <= 1'b0;
      pend_q <= 1'b0;
    end else if (en_o) begin
      lock_q <= lock_d;
      pend_q <= pend_d;
    end
  end

  assign lock_o = lock_q;
endmodule

// File: rtl/plastic_syn_lock.sv
module plastic_syn_lock #(
  parameter int W          = 8,
  parameter int STEP       = 16,
  parameter int RST_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic signed [W-1:0] seed_i,
  input  logic                pre_spike_i,
  input  logic                replay_i,
  input  logic                ltp_sel_i,
  input  logic                unlock_i,
  output logic signed [W-1:0] post_o,
  output logic                clk_en_o
);
  logic                rst_sync_n;
  logic                en;
  logic                apply;
  logic                lock_q;
  logic                lim;
  logic                spike_q;
  logic signed [W-1:0] w_q, w_d, w_step;
  logic signed [W-1:0] post_q, post_d;
  syn_pkg::dir_e       dir;

  syn_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_sync_n)
  );

  assign dir = ltp_sel_i ? syn_pkg::DIR_POTENT : syn_pkg::DIR_DEPRESS;

  syn_step_sat #(.W(W), .STEP(STEP)) u_step (
    .w_i   (w_q),
    .dir_i (dir),
    .w_o   (w_step),
    .lim_o (lim)
  );

  syn_gate_ctl u_gate (
    .clk_i       (clk_i),
    .rst_ni      (rst_sync_n),
    .pre_spike_i (pre_spike_i),
    .spike_q_i   (spike_q),
    .replay_i    (replay_i),
    .unlock_i    (unlock_i),
    .lim_i       (lim),
    .en_o        (en),
    .apply_o     (apply),
    .lock_o      (lock_q)
  );

  always_comb begin
    w_d    = apply ? w_step : w_q;
    post_d = pre_spike_i ? w_q : '0;
  end

  // weight is seeded from the input while in reset
  always_ff @(posedge clk_i) begin
    if (!rst_sync_n) w_q <= seed_i;
    else if (en)     w_q <= w_d;
  end

  always_ff @(posedge clk_i or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      spike_q <= 1'b0;
      post_q  <= '0;
    end else if (en) begin
      spike_q <= pre_spike_i;
      post_q  <= post_d;
    end
  end

  assign post_o   = post_q;
  assign clk_en_o = en;
endmodule

// File: rtl/syn_lock_chk.sv
module syn_lock_chk #(
  parameter int W    = 8,
  parameter int STEP = 16
) (
  input logic                clk_i,
  input logic                rst_n,
  input logic                pre_spike_i,
  input logic                replay_i,
  input logic                ltp_sel_i,
  input logic                unlock_i,
  input logic                clk_en_o,
  input logic                lock_q,
  input logic                spike_q,
  input logic signed [W-1:0] w_q,
  input logic signed [W-1:0] post_o
);
  localparam int MAXI = (2 ** (W - 1)) - 1;
  int w_int;
  assign w_int = int'(w_q);

  // R6
  lock_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (lock_q && !unlock_i) |=> (w_q == $past(w_q)));

  // R10
  gated_still_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    !clk_en_o |=> ($stable(w_q) && $stable(lock_q) && $stable(post_o)));

  // R7
  unlock_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    unlock_i |=> !lock_q);

  // R3
  ltp_step_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (replay_i && !lock_q && !unlock_i && ltp_sel_i && (w_int <= MAXI - STEP))
      |=> (w_int == $past(w_int) + STEP));

  // R2
  post_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    !pre_spike_i |=> (post_o == '0));

  // R9
  frozen_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (lock_q && replay_i && !unlock_i && !pre_spike_i && !spike_q) |-> !clk_en_o);
endmodule

bind plastic_syn_lock syn_lock_chk #(.W(W), .STEP(STEP)) u_chk (
  .clk_i       (clk_i),
  .rst_n       (rst_sync_n),
  .pre_spike_i (pre_spike_i),
  .replay_i    (replay_i),
  .ltp_sel_i   (ltp_sel_i),
  .unlock_i    (unlock_i),
  .clk_en_o    (clk_en_o),
  .lock_q      (lock_q),
  .spike_q     (spike_q),
  .w_q         (w_q),
  .post_o      (post_o)
);

// File: tb/plastic_syn_lock_tb.sv
`timescale 1ns/1ps
module plastic_syn_lock_tb;
  logic              clk = 1'b0;
  logic              rst_n;
  logic signed [7:0] seed;
  logic              sp, rp, lt, un;
  logic signed [7:0] post;
  logic              cen;
  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #4 clk = ~clk;

  plastic_syn_lock u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .seed_i      (seed),
    .pre_spike_i (sp),
    .replay_i    (rp),
    .ltp_sel_i   (lt),
    .unlock_i    (un),
    .post_o      (post),
    .clk_en_o    (cen)
  );

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(logic s, logic r, logic l, logic u);
    @(negedge clk);
    sp = s; rp = r; lt = l; un = u;
    #1;
  endtask

  task automatic read_w(output int v);
    cyc(1'b1, 1'b0, 1'b0, 1'b0);
    cyc(1'b0, 1'b0, 1'b0, 1'b0);
    v = int'(post);
  endtask

  task automatic t_reset();
    int v;
    rst_n = 1'b0; seed = 8'sd40;
    sp = 0; rp = 0; lt = 0; un = 0;
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) cyc(0, 0, 0, 0);
    chk("R1 post after reset", int'(post), 0);
    chk("R1 clk_en idle", int'(cen), 0);
    read_w(v);
    chk("R1 seeded weight", v, 40);
    cyc(0, 0, 0, 0);
    chk("R2 post back to zero", int'(post), 0);
    chk("R8 idle gate off", int'(cen), 0);
  endtask

  task automatic t_ltp_lock();
    int v;
    cyc(0, 1, 1, 0);
    cyc(0, 1, 1, 0);
    cyc(0, 0, 0, 0);
    chk("R6 run close enables clock", int'(cen), 1);
    cyc(0, 0, 0, 0);
    chk("R8 frozen idle gate off", int'(cen), 0);
    read_w(v);
    chk("R3 two potentiation steps", v, 72);
    cyc(0, 1, 1, 0);
    chk("R9 frozen replay gate off", int'(cen), 0);
    cyc(0, 0, 0, 0);
    read_w(v);
    chk("R6 frozen weight kept", v, 72);
  endtask

  task automatic t_unlock_ltd();
    int v;
    cyc(0, 1, 0, 1);
    chk("R7 unlock enables clock", int'(cen), 1);
    cyc(0, 0, 0, 0);
    read_w(v);
    chk("R7 no step on unlock cycle", v, 72);
    repeat (3) cyc(0, 1, 0, 0);
    cyc(0, 0, 0, 0);
    read_w(v);
    chk("R4 three depression steps", v, 24);
    cyc(0, 1, 1, 0);
    cyc(0, 0, 0, 0);
    read_w(v);
    chk("R6 frozen after depression", v, 24);
  endtask

  task automatic t_sat_high();
    int v;
    cyc(0, 0, 0, 1);
    repeat (7) cyc(0, 1, 1, 0);
    cyc(0, 1, 1, 0);
    chk("R5 limit freezes at once", int'(cen), 0);
    cyc(0, 0, 0, 0);
    read_w(v);
    chk("R5 saturate high", v, 127);
  endtask

  task automatic t_sat_low();
    int v;
    cyc(0, 0, 0, 1);
    repeat (16) cyc(0, 1, 0, 0);
    cyc(0, 1, 0, 0);
    chk("R5 low limit freezes", int'(cen), 0);
    cyc(0, 0, 0, 0);
    read_w(v);
    chk("R5 saturate low", v, -128);
    cyc(0, 0, 0, 1);
    cyc(0, 1, 1, 0);
    cyc(0, 0, 0, 0);
    read_w(v);
    chk("R7 replay updates after unlock", v, -112);
    cyc(0, 0, 0, 0);
    chk("R2 post zero after spike", int'(post), 0);
  endtask

  initial begin
    t_reset();
    t_ltp_lock();
    t_unlock_ltd();
    t_sat_high();
    t_sat_low();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule